// File: doc/BRIEF.md
# Single-Register Successive-Approximation Controller

This block is the digital half of a successive-approximation converter. It runs the binary search that turns a string of comparator decisions into a 12-bit code. One register holds two things at once: the bits already decided, and a single walking trial marker. The block has no separate sequencer. Every stage picks its next value from three sources: the value shifted down from the stage above, the comparator, or its own current value. An OR chain that runs up from the bottom decides which stages are frozen.

A pulse on `start` clears the register and places the trial 1 in the top bit. On each later clock the current trial bit takes the comparator decision, and the stage below it becomes the new trial. An extra marker stage sits below the LSB and catches the trial token after the last decision. That marker drives `eoc` and freezes the whole register. Raising `stop` pauses every stage for as long as it is held. The DAC and the comparator are outside this block. The comparator input is 1 when the held sample is at or above the value the current code represents.

Top module: `sar_nr_register`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `code` is 0 and `eoc` is 0.
- R2: A clock edge with `start` high makes `code` equal 0x800 (only bit 11 set) and `eoc` 0. This also applies when a conversion is already running.
- R3: On each step, the bit that holds the trial 1 takes the value of `comp` (1 keeps it, 0 clears it).
- R4: On the same step, the bit just below the trial becomes 1, and all bits lower than that stay 0.
- R5: Bits above the trial bit keep their decided values on every step.
- R6: `eoc` rises after exactly 12 clock edges that follow the start edge with `stop` low. `code` then equals the binary-search result, which is the input value when `comp` = (value >= code).
- R7: Once `eoc` is 1, and until the next start, `code` and `eoc` do not change, whatever `comp` does.
- R8: A clock edge with `stop` high and `start` low leaves `code` and `eoc` unchanged. The conversion carries on from where it paused once `stop` falls.
- R9: After reset and before any start, `code` stays 0 and `eoc` stays 0 whatever `comp` does.
- R10: When `start` and `stop` are high on the same edge, the start takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a new conversion |
| stop | input | 1 | Freezes every stage while high |
| comp | input | 1 | Comparator decision for the current trial bit |
| code | output | 12 | Decided bits and trial marker; the result once `eoc` is 1 |
| eoc | output | 1 | End of conversion; set by the stage below the LSB |

## Verification
The bench answers the comparator from an arithmetic model of the sampled value and runs every one of the 4096 input values. This catches any step that is wrong for some bit position or for some decision. All-zeros and all-ones drive the trial token through an unbroken run of rejects or keeps. Alternating and single-edge patterns (0xAAA, 0x555, 0x800, 0x7FF) are followed step by step against the expected partial code, so that a mistake in the trial bit is told apart from a mistake in the bits already decided. Pauses with a toggling comparator, restarts in mid-conversion, and start together with stop show that the hold chain and the start priority behave as specified.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        SEL_SHIFT = 2'd0,
        SEL_LOAD  = 2'd1,
        SEL_HOLD  = 2'd2
    } sar_sel_e;

    // Pick the source for one stage from its freeze flag and its own value.
    function automatic sar_sel_e sar_pick(input logic frozen, input logic self_q);
        if (frozen)      return SEL_HOLD;
        else if (self_q) return SEL_LOAD;
        else             return SEL_SHIFT;
    endfunction

endpackage

// File: rtl/sar_hold_chain.sv
module sar_hold_chain #(
    parameter int WIDTH = 12
) (
    input  logic             stop,
    input  logic [WIDTH:0]   stage_q,
    output logic [WIDTH:0]   frozen
);
    // Stage 0 is the end marker; stage WIDTH is the MSB.
    assign frozen[0] = stop;

    for (genvar k = 1; k <= WIDTH; k++) begin : g_link
        assign frozen[k] = frozen[k-1] | stage_q[k-1];
    end
endmodule

// File: rtl/sar_bit_cell.sv
module sar_bit_cell
    import sar_pkg::*;
(
    input  logic frozen,
    input  logic self_q,
    input  logic upper_q,
    input  logic comp,
    output logic next_d
);
    sar_sel_e sel;

    always_comb begin
        sel = sar_pick(frozen, self_q);
        unique case (sel)
            SEL_HOLD:  next_d = self_q;
            SEL_LOAD:  next_d = comp;
            default:   next_d = upper_q;
        endcase
    end
endmodule

// File: rtl/sar_nr_register.sv
module sar_nr_register #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic             comp,
    output logic [WIDTH-1:0] code,
    output logic             eoc
);
    localparam int TOP = WIDTH;

    typedef struct packed {
        logic [WIDTH:0] stage;
    } sar_state_t;

    sar_state_t     st_d, st_q;
    logic [WIDTH:0] frozen;
    logic [WIDTH:0] cell_d;

    sar_hold_chain #(.WIDTH(WIDTH)) chain_i (
        .stop    (stop),
        .stage_q (st_q.stage),
        .frozen  (frozen)
    );

    for (genvar k = 1; k <= WIDTH; k++) begin : g_cell
        logic upper;
        if (k == TOP) begin : g_msb
            assign upper = 1'b0;
        end else begin : g_mid
            assign upper = st_q.stage[k+1];
        end
        sar_bit_cell cell_i (
            .frozen  (frozen[k]),
            .self_q  (st_q.stage[k]),
            .upper_q (upper),
            .comp    (comp),
            .next_d  (cell_d[k])
        );
    end

    // End marker: catches the token from the LSB, then holds.
    assign cell_d[0] = (frozen[0] | st_q.stage[0]) ? st_q.stage[0] : st_q.stage[1];

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.stage      = '0;
            st_d.stage[TOP] = 1'b1;
        end else begin
            st_d.stage = cell_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign code = st_q.stage[WIDTH:1];
    assign eoc  = st_q.stage[0];
endmodule

// File: rtl/sar_nr_register_chk.sv
module sar_nr_register_chk #(
    parameter int WIDTH = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             stop,
    input logic             comp,
    input logic [WIDTH-1:0] code,
    input logic             eoc
);
    localparam int CW = $clog2(WIDTH + 2);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    logic [CW-1:0] steps;
    logic          busy;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            steps <= '0;
            busy  <= 1'b0;
            armed <= 1'b0;
        end else if (start) begin
            steps <= '0;
            busy  <= 1'b1;
            armed <= 1'b1;
        end else if (busy && !stop) begin
            if (eoc)              busy  <= 1'b0;
            else if (steps != '1) steps <= steps + 1'b1;
        end
    end

    a_r2_start_arms: assert property (@(posedge clk) disable iff (rst)
        start |=> (code == MSB_ONLY) && !eoc);

    a_r7_done_frozen: assert property (@(posedge clk) disable iff (rst)
        (eoc && !start) |=> eoc && $stable(code));

    a_r8_stop_freezes: assert property (@(posedge clk) disable iff (rst)
        (stop && !start) |=> $stable(code) && $stable(eoc));

    a_r6_step_count: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc) |-> (steps == CW'(WIDTH)));

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (code == '0) && !eoc);

    a_r10_start_wins: assert property (@(posedge clk) disable iff (rst)
        (start && stop) |=> (code == MSB_ONLY));

    logic unused_ok;
    assign unused_ok = comp;
endmodule

bind sar_nr_register sar_nr_register_chk #(.WIDTH(WIDTH)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .stop  (stop),
    .comp  (comp),
    .code  (code),
    .eoc   (eoc)
);

// File: tb/sar_nr_register_tb_top.sv
module sar_nr_register_tb_top;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst, start, stop, comp;
    logic [W-1:0] code;
    logic         eoc;
    int           n_run = 0;
    int           n_fail = 0;

    always #4 clk = ~clk;

    sar_nr_register #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .comp(comp), .code(code), .eoc(eoc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int partial(input int vin, input int i);
        int keep = (vin >> (W - i)) << (W - i);
        return (i < W) ? (keep | (1 << (W - 1 - i))) : keep;
    endfunction

    task automatic begin_conv(input bit with_stop);
        @(negedge clk); start = 1'b1; stop = with_stop; comp = 1'b0;
        @(negedge clk); start = 1'b0; stop = 1'b0;
    endtask

    // Runs the 12 decision steps; optional per-step checks (R3, R4, R5).
    task automatic decide(input int vin, input bit step_chk, input int from_i);
        for (int i = from_i; i <= W; i++) begin
            comp = (vin >= int'(code));
            @(negedge clk);
            if (step_chk) begin
                chk(int'(code) == partial(vin, i), "R3 R4 R5 step code", code, partial(vin, i));
                chk(eoc == (i == W), "R6 eoc timing", eoc, (i == W));
            end else if (i == W - 1) begin
                chk(!eoc, "R6 eoc not early", eoc, 0);
            end
        end
        chk(int'(code) == vin && eoc, "R6 final code", code, vin);
    endtask

    initial begin
        #1_200_000;
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int pats[6];
        pats = '{0, 4095, 'hAAA, 'h555, 'h800, 'h7FF};
        rst = 1'b1; start = 1'b0; stop = 1'b0; comp = 1'b0;
        repeat (3) @(negedge clk);
        chk(code == '0 && !eoc, "R1 reset state", code, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(code == '0 && !eoc, "R1 after reset", code, 0);

        // R9: idle with toggling comparator
        for (int i = 0; i < 6; i++) begin
            comp = i[0];
            @(negedge clk);
            chk(code == '0 && !eoc, "R9 idle", code, 0);
        end

        // Step-by-step patterns
        foreach (pats[p]) begin
            begin_conv(1'b0);
            chk(code == 12'h800 && !eoc, "R2 armed", code, 'h800);
            decide(pats[p], 1'b1, 1);
            // R7: comparator ignored after completion
            for (int j = 0; j < 4; j++) begin
                comp = ~comp;
                @(negedge clk);
                chk(int'(code) == pats[p] && eoc, "R7 frozen result", code, pats[p]);
            end
        end

        // R8: pause mid-conversion with toggling comparator
        begin_conv(1'b0);
        for (int i = 1; i <= 5; i++) begin
            comp = ('h6B3 >= int'(code));
            @(negedge clk);
        end
        stop = 1'b1;
        for (int j = 0; j < 4; j++) begin
            comp = j[0];
            @(negedge clk);
            chk(int'(code) == partial('h6B3, 5) && !eoc, "R8 paused", code, partial('h6B3, 5));
        end
        stop = 1'b0;
        decide('h6B3, 1'b1, 6);

        // R2: restart during a conversion
        begin_conv(1'b0);
        for (int i = 1; i <= 4; i++) begin
            comp = ('h123 >= int'(code));
            @(negedge clk);
        end
        begin_conv(1'b0);
        chk(code == 12'h800 && !eoc, "R2 restart", code, 'h800);
        decide('hF0F, 1'b0, 1);

        // R10: start together with stop
        begin_conv(1'b1);
        chk(code == 12'h800 && !eoc, "R10 start over stop", code, 'h800);
        decide('h3C5, 1'b0, 1);

        // R6: full sweep of input values
        for (int v = 0; v < (1 << W); v++) begin
            begin_conv(1'b0);
            decide(v, 1'b0, 1);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule